// File: doc/BRIEF.md
# Banked Register Window with Pointer Data Port

This block sits between a narrow host bus and a packet buffer. The host sees a window of sixteen byte addresses. A bank-select byte picks which of four register sets the lower addresses reach. The bank-select byte and a fixed identification byte are visible at the top of the window in every bank. In the packet bank, a 16-bit pointer register and a packet-number register together form the address of a byte in packet memory. Four data-port addresses then read or write that byte through a simple memory port.

The page is taken either from the packet-number register or from the head entry of the receive queue, which comes in on a port. The choice is made by the pointer's top bit. The next bit sets whether the pointer steps forward after each data-port byte or holds still while the bus address supplies a lane offset.

A host access may be one, two or four bytes wide. The block breaks it into single-byte operations on consecutive addresses, one per clock, and returns the assembled read data with a one-cycle done pulse. A four-byte write aimed at offset 12 is trimmed so that only the top two bytes of the window are written.

Top module: `banked_window`

## Requirements
- R1: After reset, the bank-select byte reads 0, the pointer reads 0x0000, the packet number reads 0, and the early-receive field in bank 3 reads 0x1F.
- R2: Offset 14 stores and returns a full bank-select byte in every bank. Offset 15 always reads 0x33, and writes to it change nothing.
- R3: Pointer bit 15 picks the page: when set, the page is `rxq_head`; when clear, the page is the packet-number register. The memory address is {page[1:0], 11-bit offset}.
- R4: With pointer bit 14 set, a data-port byte (offsets 8 to 11, bank 2) uses the pointer's low 11 bits as the offset. It then increments those bits modulo 2048, and pointer bits 15:11 stay unchanged.
- R5: With pointer bit 14 clear, the offset is the pointer's low 11 bits plus bits 1:0 of the byte address, modulo 2048, and the pointer does not change.
- R6: A read of the pointer high byte (offset 7, bank 2) returns the stored byte ANDed with 0xF7. The hidden bit is still stored.
- R7: When the selected page is 4 or more, a data-port byte causes no memory read or write and does not move the pointer, and a read returns 0.
- R8: In bank 3, offsets 9 and 11 read 0x33 and offset 10 reads 0x91. Offset 12 holds a 5-bit early-receive value that keeps the low 5 bits of a write. Offset 13 reads 0.
- R9: Size code 0 is one byte, 1 is two bytes and 2 is four bytes. Byte i goes to address (addr + i) mod 16 and to data lane i (bits 8i+7:8i). The bytes are processed in ascending order, one per clock. `acc_done` is a single-cycle pulse.
- R10: A four-byte write at offset 12 writes only offsets 14 (from wdata[23:16]) and 15. Offsets 12 and 13 are untouched. A four-byte read at offset 12 returns all four bytes.
- R11: In bank 2, offset 2 is the read/write packet number and offsets 6 and 7 are the pointer. In any bank other than 2 or 3, including bank values of 4 and above, offsets 0 to 13 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Start a host access (taken when idle) |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Window byte address of the first byte |
| acc_size | input | 2 | 0 byte, 1 two bytes, 2 four bytes |
| acc_wdata | input | 32 | Write data, lane i for byte i |
| acc_done | output | 1 | One-cycle pulse after the last byte |
| acc_rdata | output | 32 | Assembled read data, valid with acc_done |
| rxq_head | input | 8 | Page number at the head of the receive queue |
| mem_addr | output | 13 | Packet memory byte address {page, offset} |
| mem_we | output | 1 | Packet memory byte write strobe |
| mem_re | output | 1 | Packet memory byte read strobe |
| mem_wdata | output | 8 | Packet memory write byte |
| mem_rdata | input | 8 | Packet memory read byte (combinational) |

## Verification
The bench drives the pointer across the 2047-to-0 boundary in auto-step mode. A design that carried into the upper pointer bits, or that added the lane offset as well as stepping, would read and write the wrong memory bytes and report the wrong final pointer. It selects page numbers of 4 and above while the memory model returns non-zero data at the truncated address, so a design that only truncated the page would leak data or write memory. It also covers the trimmed four-byte write at offset 12, wraparound of a two-byte access at offset 15, the masked pointer high byte and bank values above 3, each of which fails in a visible way: a moved early-receive value, a wrong lane, or a non-zero read.

// File: rtl/banked_window_pkg.sv
package banked_window_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam logic [3:0] OFS_BANK_SEL = 4'd14;
    localparam logic [3:0] OFS_ID       = 4'd15;
    localparam logic [3:0] OFS_PNUM     = 4'd2;
    localparam logic [3:0] OFS_PTR_LO   = 4'd6;
    localparam logic [3:0] OFS_PTR_HI   = 4'd7;
    localparam logic [3:0] OFS_ERX      = 4'd12;
    localparam logic [3:0] OFS_SKIP     = 4'd12;

    localparam logic [7:0] ID_BYTE     = 8'h33;
    localparam logic [7:0] REV_BYTE    = 8'h91;
    localparam logic [7:0] PTR_HI_MASK = 8'hF7;
    localparam logic [4:0] ERX_RESET   = 5'h1F;

    localparam int PTR_W        = 16;
    localparam int PTR_PAGE_BIT = 15;
    localparam int PTR_AUTO_BIT = 14;

    typedef struct packed {
        logic        busy;
        logic        we;
        logic [3:0]  base;
        logic [1:0]  idx;
        logic [1:0]  last;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        done;
    } seq_t;

    typedef struct packed {
        logic [7:0]       bank;
        logic [PTR_W-1:0] ptr;
        logic [7:0]       pnum;
        logic [4:0]       erx;
    } regs_t;

endpackage

// File: rtl/bw_byte_splitter.sv
module bw_byte_splitter
    import banked_window_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_we,
    input  logic [3:0]  acc_addr,
    input  logic [1:0]  acc_size,
    input  logic [31:0] acc_wdata,
    input  logic [7:0]  byte_rdata,
    output logic        acc_done,
    output logic [31:0] acc_rdata,
    output logic        byte_en,
    output logic        byte_we,
    output logic [3:0]  byte_addr,
    output logic [7:0]  byte_wdata
);

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!seq_q.busy) begin
            if (acc_valid) begin
                seq_d.busy  = 1'b1;
                seq_d.we    = acc_we;
                seq_d.base  = acc_addr;
                seq_d.wdata = acc_wdata;
                seq_d.rdata = '0;
                case (acc_size)
                    SZ_BYTE: seq_d.last = 2'd0;
                    SZ_HALF: seq_d.last = 2'd1;
                    default: seq_d.last = 2'd3;
                endcase
                seq_d.idx = (acc_we && acc_size == SZ_WORD && acc_addr == OFS_SKIP)
                            ? 2'd2 : 2'd0;
            end
        end else begin
            if (!seq_q.we) begin
                seq_d.rdata[{seq_q.idx, 3'b000} +: 8] = byte_rdata;
            end
            if (seq_q.idx == seq_q.last) begin
                seq_d.busy = 1'b0;
                seq_d.done = 1'b1;
            end else begin
                seq_d.idx = seq_q.idx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign acc_done   = seq_q.done;
    assign acc_rdata  = seq_q.rdata;
    assign byte_en    = seq_q.busy;
    assign byte_we    = seq_q.we;
    assign byte_addr  = seq_q.base + {2'b00, seq_q.idx};
    assign byte_wdata = seq_q.wdata[{seq_q.idx, 3'b000} +: 8];

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    // R9: bytes walk upward one address per clock
    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.idx != seq_q.last) |=> (byte_addr == $past(byte_addr) + 4'd1));

    // R10: a four-byte write at offset 12 starts at offset 14
    assert_word_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !seq_q.busy && acc_we && acc_size == SZ_WORD && acc_addr == OFS_SKIP)
        |=> (byte_en && byte_addr == OFS_BANK_SEL));

endmodule

// File: rtl/bw_page_addr.sv
module bw_page_addr #(
    parameter int NUM_PAGES = 4,
    parameter int PAGE_W    = 2,
    parameter int OFS_W     = 11,
    localparam int MEM_AW   = PAGE_W + OFS_W
) (
    input  logic              ptr_from_rxq,
    input  logic              ptr_auto,
    input  logic [OFS_W-1:0]  ptr_ofs,
    input  logic [7:0]        pnum,
    input  logic [7:0]        rxq_head,
    input  logic [1:0]        lane,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              page_ok
);

    logic [7:0]       page;
    logic [OFS_W-1:0] ofs;

    always_comb begin
        page    = ptr_from_rxq ? rxq_head : pnum;
        page_ok = (32'(page) < NUM_PAGES);
        ofs     = ptr_auto ? ptr_ofs : ptr_ofs + OFS_W'(lane);
    end

    assign mem_addr = {page[PAGE_W-1:0], ofs};

endmodule

// File: rtl/bw_regfile.sv
module bw_regfile
    import banked_window_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_en,
    input  logic             byte_we,
    input  logic [3:0]       byte_addr,
    input  logic [7:0]       byte_wdata,
    input  logic             page_ok,
    input  logic [7:0]       mem_rdata,
    output logic [7:0]       byte_rdata,
    output logic [PTR_W-1:0] ptr,
    output logic [7:0]       pnum,
    output logic             mem_we,
    output logic             mem_re,
    output logic [7:0]       mem_wdata
);

    regs_t regs_d, regs_q;
    logic  wr;
    logic  data_sel;

    always_comb begin
        wr       = byte_en && byte_we;
        data_sel = (regs_q.bank == 8'd2) && (byte_addr[3:2] == 2'b10);
    end

    always_comb begin
        regs_d     = regs_q;
        byte_rdata = 8'h00;
        if (byte_addr == OFS_BANK_SEL) begin
            byte_rdata = regs_q.bank;
            if (wr) regs_d.bank = byte_wdata;
        end else if (byte_addr == OFS_ID) begin
            byte_rdata = ID_BYTE;
        end else if (regs_q.bank == 8'd2) begin
            case (byte_addr)
                OFS_PNUM: begin
                    byte_rdata = regs_q.pnum;
                    if (wr) regs_d.pnum = byte_wdata;
                end
                OFS_PTR_LO: begin
                    byte_rdata = regs_q.ptr[7:0];
                    if (wr) regs_d.ptr[7:0] = byte_wdata;
                end
                OFS_PTR_HI: begin
                    byte_rdata = regs_q.ptr[15:8] & PTR_HI_MASK;
                    if (wr) regs_d.ptr[15:8] = byte_wdata;
                end
                4'd8, 4'd9, 4'd10, 4'd11: begin
                    if (page_ok) begin
                        byte_rdata = mem_rdata;
                        if (byte_en && regs_q.ptr[PTR_AUTO_BIT]) begin
                            regs_d.ptr[OFS_W-1:0] = regs_q.ptr[OFS_W-1:0] + OFS_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end else if (regs_q.bank == 8'd3) begin
            case (byte_addr)
                4'd9, 4'd11: byte_rdata = ID_BYTE;
                4'd10:       byte_rdata = REV_BYTE;
                OFS_ERX: begin
                    byte_rdata = {3'b000, regs_q.erx};
                    if (wr) regs_d.erx = byte_wdata[4:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.bank <= 8'h00;
            regs_q.ptr  <= '0;
            regs_q.pnum <= 8'h00;
            regs_q.erx  <= ERX_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ptr       = regs_q.ptr;
    assign pnum      = regs_q.pnum;
    assign mem_we    = byte_en && byte_we && data_sel && page_ok;
    assign mem_re    = byte_en && !byte_we && data_sel && page_ok;
    assign mem_wdata = byte_wdata;

    // R4: auto-step advances the low offset bits, upper bits kept
    assert_autostep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && data_sel && page_ok && regs_q.ptr[PTR_AUTO_BIT])
        |=> (regs_q.ptr[OFS_W-1:0] == OFS_W'($past(regs_q.ptr[OFS_W-1:0]) + OFS_W'(1))
             && regs_q.ptr[PTR_W-1:OFS_W] == $past(regs_q.ptr[PTR_W-1:OFS_W])));

    // R5: lane-offset mode leaves the pointer alone
    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && data_sel && !regs_q.ptr[PTR_AUTO_BIT]) |=> $stable(regs_q.ptr));

    // R7: an out-of-range page never moves the pointer
    assert_badpage_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && data_sel && !page_ok) |=> $stable(regs_q.ptr));

    // R8: early-receive field written with the low five bits
    assert_erx_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && regs_q.bank == 8'd3 && byte_addr == OFS_ERX)
        |=> (regs_q.erx == $past(byte_wdata[4:0])));

endmodule

// File: rtl/banked_window.sv
module banked_window
    import banked_window_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int OFS_W     = 11,
    localparam int PAGE_W   = $clog2(NUM_PAGES),
    localparam int MEM_AW   = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [3:0]        acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic              acc_done,
    output logic [31:0]       acc_rdata,
    input  logic [7:0]        rxq_head,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    logic             byte_en;
    logic             byte_we;
    logic [3:0]       byte_addr;
    logic [7:0]       byte_wdata;
    logic [7:0]       byte_rdata;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       pnum;
    logic             page_ok;

    bw_byte_splitter u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_we     (acc_we),
        .acc_addr   (acc_addr),
        .acc_size   (acc_size),
        .acc_wdata  (acc_wdata),
        .byte_rdata (byte_rdata),
        .acc_done   (acc_done),
        .acc_rdata  (acc_rdata),
        .byte_en    (byte_en),
        .byte_we    (byte_we),
        .byte_addr  (byte_addr),
        .byte_wdata (byte_wdata)
    );

    bw_page_addr #(
        .NUM_PAGES (NUM_PAGES),
        .PAGE_W    (PAGE_W),
        .OFS_W     (OFS_W)
    ) u_addr (
        .ptr_from_rxq (ptr[PTR_PAGE_BIT]),
        .ptr_auto     (ptr[PTR_AUTO_BIT]),
        .ptr_ofs      (ptr[OFS_W-1:0]),
        .pnum         (pnum),
        .rxq_head     (rxq_head),
        .lane         (byte_addr[1:0]),
        .mem_addr     (mem_addr),
        .page_ok      (page_ok)
    );

    bw_regfile #(
        .OFS_W (OFS_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (byte_en),
        .byte_we    (byte_we),
        .byte_addr  (byte_addr),
        .byte_wdata (byte_wdata),
        .page_ok    (page_ok),
        .mem_rdata  (mem_rdata),
        .byte_rdata (byte_rdata),
        .ptr        (ptr),
        .pnum       (pnum),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_wdata  (mem_wdata)
    );

    // R7: no memory strobe while the selected page is out of range
    assert_no_strobe_badpage_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !page_ok |-> !(mem_we || mem_re));

endmodule

// File: tb/banked_window_tb_top.sv
`timescale 1ns/1ps
module banked_window_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_we = 1'b0;
    logic [3:0]  acc_addr = 4'h0;
    logic [1:0]  acc_size = 2'd0;
    logic [31:0] acc_wdata = 32'h0;
    logic        acc_done;
    logic [31:0] acc_rdata;
    logic [7:0]  rxq_head = 8'h00;
    logic [12:0] mem_addr;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int failures = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    bit finished = 1'b0;

    logic [7:0] tbmem [0:8191];

    logic [31:0] exp_q[$];
    logic [31:0] msk_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    banked_window dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_wdata (acc_wdata),
        .acc_done  (acc_done),
        .acc_rdata (acc_rdata),
        .rxq_head  (rxq_head),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    assign mem_rdata = tbmem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            tbmem[mem_addr] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (mem_re) re_cnt <= re_cnt + 1;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && acc_done) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9 unexpected done act=%h exp=none", acc_rdata);
            end else begin
                logic [31:0] e;
                logic [31:0] m;
                string t;
                e = exp_q.pop_front();
                m = msk_q.pop_front();
                t = tag_q.pop_front();
                if (m != 32'h0) begin
                    checks++;
                    if ((acc_rdata & m) != e) begin
                        failures++;
                        $display("FAIL %s act=%h exp=%h", t, acc_rdata & m, e);
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit we, input logic [3:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] exp, input string tag);
        logic [31:0] m;
        if (we) m = 32'h0;
        else if (sz == 2'd0) m = 32'h0000_00FF;
        else if (sz == 2'd1) m = 32'h0000_FFFF;
        else m = 32'hFFFF_FFFF;
        exp_q.push_back(exp);
        msk_q.push_back(m);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_we    = we;
        acc_addr  = a;
        acc_size  = sz;
        acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        while (!acc_done) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] wd);
        acc(1'b1, a, sz, wd, 32'h0, "write");
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] exp,
                      input string tag);
        acc(1'b0, a, sz, 32'h0, exp, tag);
    endtask

    initial begin
        int wc;
        for (int i = 0; i < 8192; i++) tbmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(4'd14, 2'd0, 32'h00, "R1 bank reset");
        rd(4'd2,  2'd0, 32'h00, "R11 bank0 offset2 zero");
        wr(4'd14, 2'd0, 32'h02);
        rd(4'd2,  2'd0, 32'h00, "R1 pnum reset");
        rd(4'd6,  2'd1, 32'h0000, "R1 ptr reset");
        wr(4'd14, 2'd0, 32'h03);
        rd(4'd12, 2'd0, 32'h1F, "R1 erx reset");

        // R2 bank select and id byte
        wr(4'd15, 2'd0, 32'h55);
        rd(4'd15, 2'd0, 32'h33, "R2 id byte");
        rd(4'd14, 2'd0, 32'h03, "R2 bank readback");
        wr(4'd14, 2'd0, 32'h07);
        rd(4'd14, 2'd0, 32'h07, "R2 bank full byte");
        rd(4'd15, 2'd0, 32'h33, "R2 id byte bank7");
        wr(4'd2, 2'd0, 32'h44);
        rd(4'd2, 2'd0, 32'h00, "R11 bank7 reads zero");
        wr(4'd14, 2'd0, 32'h02);
        rd(4'd2, 2'd0, 32'h00, "R11 bank7 write ignored");

        // R11 packet number
        wr(4'd2, 2'd0, 32'h01);
        rd(4'd2, 2'd0, 32'h01, "R11 pnum rw");

        // R5 / R3 / R9 lane mode
        wr(4'd6, 2'd1, 32'h0010);
        wr(4'd8, 2'd2, 32'hDDCC_BBAA);
        chk("R5 mem lane0", {24'h0, tbmem[13'h810]}, 32'hAA);
        chk("R5 mem lane3", {24'h0, tbmem[13'h813]}, 32'hDD);
        chk("R3 page0 untouched", {24'h0, tbmem[13'h010]}, 32'h00);
        rd(4'd6, 2'd1, 32'h0010, "R5 ptr held");
        rd(4'd8, 2'd2, 32'hDDCC_BBAA, "R9 word read lanes");

        // R4 auto-step across 2047 -> 0
        wr(4'd6, 2'd1, 32'h47FE);
        wr(4'd8, 2'd2, 32'h4433_2211);
        chk("R4 mem 7FE", {24'h0, tbmem[13'h800 + 13'h7FE]}, 32'h11);
        chk("R4 mem 7FF", {24'h0, tbmem[13'h800 + 13'h7FF]}, 32'h22);
        chk("R4 mem wrap0", {24'h0, tbmem[13'h800]}, 32'h33);
        chk("R4 mem wrap1", {24'h0, tbmem[13'h801]}, 32'h44);
        rd(4'd6, 2'd1, 32'h4002, "R4 ptr after wrap");
        wr(4'd6, 2'd1, 32'h47FE);
        rd(4'd8, 2'd2, 32'h4433_2211, "R4 auto read");
        rd(4'd6, 2'd1, 32'h4002, "R4 ptr after read");

        // R6 masked high byte
        wr(4'd6, 2'd1, 32'h0810);
        rd(4'd7, 2'd0, 32'h00, "R6 hi masked");
        rd(4'd8, 2'd2, 32'hDDCC_BBAA, "R6 offset ignores bit11");

        // R3 page from receive queue head
        rxq_head = 8'd2;
        wr(4'd6, 2'd1, 32'h8020);
        wr(4'd8, 2'd0, 32'h5A);
        chk("R3 rxq page written", {24'h0, tbmem[13'h1020]}, 32'h5A);
        chk("R3 pnum page untouched", {24'h0, tbmem[13'h0820]}, 32'h00);

        // R7 out-of-range pages
        rxq_head = 8'd5;
        wr(4'd6, 2'd1, 32'hC000);
        wc = we_cnt;
        wr(4'd9, 2'd0, 32'h77);
        rd(4'd8, 2'd0, 32'h00, "R7 bad rxq page reads zero");
        chk("R7 no mem write", we_cnt, wc);
        rd(4'd6, 2'd1, 32'hC000, "R7 ptr not stepped");
        wr(4'd2, 2'd0, 32'h05);
        wr(4'd6, 2'd1, 32'h0010);
        rd(4'd8, 2'd0, 32'h00, "R7 bad pnum page reads zero");

        // R8 bank 3 constants
        wr(4'd14, 2'd0, 32'h03);
        rd(4'd10, 2'd0, 32'h91, "R8 revision");
        rd(4'd8, 2'd2, 32'h3391_3300, "R8 constants word");
        rd(4'd13, 2'd0, 32'h00, "R8 offset13 zero");
        wr(4'd12, 2'd0, 32'hEA);
        rd(4'd12, 2'd0, 32'h0A, "R8 erx five bits");

        // R10 trimmed word write at offset 12
        wr(4'd12, 2'd2, 32'h1202_3456);
        rd(4'd14, 2'd0, 32'h02, "R10 bank from lane2");
        wr(4'd14, 2'd0, 32'h03);
        rd(4'd12, 2'd0, 32'h0A, "R10 erx untouched");
        rd(4'd12, 2'd2, 32'h3303_000A, "R10 word read at 12");

        // R9 wrap of a two-byte access
        rd(4'd15, 2'd1, 32'h0033, "R9 half wrap at 15");

        repeat (4) @(negedge clk);
        chk("R9 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule